// File: doc/BRIEF.md
# Binary Sub-Second Counter with Alarms and Tamper Timestamp

This block keeps a free-running binary down-counter that steps once per prescaler tick. The counter starts at all ones after reset. Two alarm comparators watch the counter. Each one compares a programmable number of low-order counter bits against its own alarm value. On a match it raises a sticky flag. It can also reload the counter to all ones in place of the normal decrement.

A tamper input, when timestamping is enabled, copies the counter into a capture register and raises a timestamp flag. A tamper that arrives while that flag is still pending raises an overflow flag instead. The capture register then keeps its earlier value.

The block is built so that two timing windows lose nothing:
- A rewrite of an alarm value during the tick that matches the old value does not cancel that match.
- A tamper that lands on, or just after, a timestamp-flag clear is never dropped.

A single interrupt line combines the enabled flags.

Top module: `ssc_alarm_stamp`

## Requirements
- R1: After reset the counter reads all ones, and every flag and the interrupt read 0.
- R2: The counter changes only on a cycle with `tick_i` high. In that cycle it decrements by one, unless an auto-clear alarm fires.
- R3: An alarm whose mask value is 0 is disabled: it never sets its flag and never reloads the counter. A mask value n from 1 to 31 compares counter bits [n-1:0]. A mask value of 32 or more compares all 32 bits.
- R4: An alarm event is a tick whose pre-tick counter value matches the alarm. The alarm flag reads 1 in the cycle after that tick, and not before.
- R5: If alarm k fires and its auto-clear bit (`alm_reload_i[k]`, with k=0 for alarm A and k=1 for alarm B) is set, the counter becomes all ones instead of decrementing. Without that bit the counter decrements.
- R6: If the counter matched an alarm value at any point during a tick period, including the cycle just before the tick, the event and its reload still happen when the alarm value is rewritten in the tick cycle itself.
- R7: Alarm flag k is cleared by `alm_clr_i[k]`. A set and a clear in the same cycle leave the flag set. A cleared flag stays 0 until the next match event.
- R8: With `ts_en_i` high, a `tamper_i` cycle captures the counter value of that cycle into `stamp_o`, and `ts_flag_o` reads 1 in the next cycle. With `ts_en_i` low, a tamper has no effect.
- R9: A tamper while `ts_flag_o` is set, and not being cleared in that cycle, sets `tso_flag_o` and leaves `stamp_o` unchanged. The overflow flag is cleared by `tso_clr_i`.
- R10: A tamper in the same cycle as `ts_clr_i`, or in any cycle after it, is never lost. A tamper in the clear cycle captures the counter and sets `ts_flag_o`.
- R11: `irq_o` is the OR of the following terms: each alarm flag ANDed with its bit of `alm_ie_i`, and `ts_flag_o` ANDed with `ts_ie_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Prescaler tick, one cycle wide |
| alm_val_i | input | 2x32 | Alarm values; index 0 is alarm A |
| alm_msk_i | input | 2x6 | Count of low bits compared per alarm; 0 disables the alarm |
| alm_reload_i | input | 2 | Auto-clear enable per alarm |
| alm_clr_i | input | 2 | Alarm flag clear pulses |
| alm_ie_i | input | 2 | Alarm interrupt enables |
| ts_en_i | input | 1 | Timestamp-on-tamper enable |
| tamper_i | input | 1 | Tamper event pulse |
| ts_clr_i | input | 1 | Timestamp flag clear pulse |
| tso_clr_i | input | 1 | Timestamp overflow flag clear pulse |
| ts_ie_i | input | 1 | Timestamp interrupt enable |
| cnt_o | output | 32 | Current counter value |
| alm_flag_o | output | 2 | Alarm flags |
| ts_flag_o | output | 1 | Timestamp flag |
| tso_flag_o | output | 1 | Timestamp overflow flag |
| stamp_o | output | 32 | Captured counter value |
| irq_o | output | 1 | Combined interrupt |

## Verification
The comparators are tried with three mask settings, and the counter is walked through several ticks for each:
- A 4-bit partial mask: this shows that only the low bits decide a match.
- A full-width mask: this exercises the reload.
- A zero mask on a value the counter actually passes: this separates a disabled alarm from a missed compare.

The rewrite test changes the alarm value in the tick cycle. It shows whether the match is remembered or sampled only at the tick. Tamper pulses are applied in four states of the flags:
- flag idle;
- flag pending;
- on the clear cycle;
- one cycle after the clear.

These four cases separate capture from overflow and expose any tamper that is dropped.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  // Returns a 64-bit vector with the lowest n bits set.
  function automatic logic [63:0] low_ones(input int n);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = (i < n);
    return r;
  endfunction
endpackage

// File: rtl/ssc_counter.sv
module ssc_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             reload_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     cnt_q <= '1;
    else if (tick_i) cnt_q <= reload_i ? '1 : cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;

  // R2: no tick, no change
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_o));
  // R5: an auto-clear event leaves the counter at all ones
  p_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && reload_i) |=> (&cnt_o));
endmodule

// File: rtl/ssc_alarm_unit.sv
module ssc_alarm_unit #(
  parameter int CNT_W = 32,
  parameter int MSK_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic [MSK_W-1:0] msk_i,
  input  logic             clr_i,
  output logic             evt_o,
  output logic             flag_o
);
  // Compares the selected low bits; a zero mask count disables the compare.
  function automatic logic masked_eq(input logic [CNT_W-1:0] c,
                                     input logic [CNT_W-1:0] v,
                                     input logic [MSK_W-1:0] m);
    logic [63:0] ones;
    ones = ssc_pkg::low_ones(int'(m));
    return (m != '0) && (((c ^ v) & ones[CNT_W-1:0]) == '0);
  endfunction

  logic [CNT_W-1:0] val_prev_q;
  logic [MSK_W-1:0] msk_prev_q;
  logic             hit_q, flag_q;
  logic             match_now_w, match_prev_w;

  assign match_now_w  = masked_eq(cnt_i, val_i, msk_i);
  assign match_prev_w = masked_eq(cnt_i, val_prev_q, msk_prev_q);
  assign evt_o        = tick_i && (hit_q || match_now_w || match_prev_w);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      val_prev_q <= '0;
      msk_prev_q <= '0;
      hit_q      <= 1'b0;
      flag_q     <= 1'b0;
    end else begin
      val_prev_q <= val_i;
      msk_prev_q <= msk_i;
      if (tick_i)           hit_q <= 1'b0;
      else if (match_now_w) hit_q <= 1'b1;
      if (evt_o)      flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  // R4: an event shows up on the flag one cycle later
  p_alarm_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> flag_o);
  // R3: a mask held at zero with no remembered hit yields no event
  p_mask_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_q && msk_i == '0 && msk_prev_q == '0) |-> !evt_o);
  // R7: a clear with no event empties the flag
  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !evt_o) |=> !flag_o);
endmodule

// File: rtl/ssc_stamp_unit.sv
module ssc_stamp_unit #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             en_i,
  input  logic             tamper_i,
  input  logic             ts_clr_i,
  input  logic             tso_clr_i,
  output logic             ts_flag_o,
  output logic             tso_flag_o,
  output logic [CNT_W-1:0] stamp_o
);
  logic             ts_q, tso_q;
  logic [CNT_W-1:0] stamp_q;
  logic             take_w, busy_w, capture_w, over_w;

  assign take_w    = tamper_i && en_i;
  assign busy_w    = ts_q && !ts_clr_i;  // a clear this cycle frees the slot
  assign capture_w = take_w && !busy_w;
  assign over_w    = take_w && busy_w;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ts_q    <= 1'b0;
      tso_q   <= 1'b0;
      stamp_q <= '0;
    end else begin
      if (capture_w)     ts_q <= 1'b1;
      else if (ts_clr_i) ts_q <= 1'b0;
      if (over_w)         tso_q <= 1'b1;
      else if (tso_clr_i) tso_q <= 1'b0;
      if (capture_w) stamp_q <= cnt_i;
    end
  end

  assign ts_flag_o  = ts_q;
  assign tso_flag_o = tso_q;
  assign stamp_o    = stamp_q;

  // R9: a tamper on a pending flag raises overflow and keeps the capture
  p_ovf_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tamper_i && en_i && ts_flag_o && !ts_clr_i) |=> (tso_flag_o && $stable(stamp_o)));
  // R10: an enabled tamper always leaves a flag behind
  p_no_loss_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tamper_i && en_i) |=> (ts_flag_o || tso_flag_o));
  // R8: a disabled tamper cannot raise the flag
  p_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ts_flag_o && !(tamper_i && en_i)) |=> !ts_flag_o);
endmodule

// File: rtl/ssc_alarm_stamp.sv
module ssc_alarm_stamp #(
  parameter int CNT_W = 32,
  parameter int NALM  = 2,
  parameter int MSK_W = $clog2(CNT_W + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       tick_i,
  input  logic [NALM-1:0][CNT_W-1:0] alm_val_i,
  input  logic [NALM-1:0][MSK_W-1:0] alm_msk_i,
  input  logic [NALM-1:0]            alm_reload_i,
  input  logic [NALM-1:0]            alm_clr_i,
  input  logic [NALM-1:0]            alm_ie_i,
  input  logic                       ts_en_i,
  input  logic                       tamper_i,
  input  logic                       ts_clr_i,
  input  logic                       tso_clr_i,
  input  logic                       ts_ie_i,
  output logic [CNT_W-1:0]           cnt_o,
  output logic [NALM-1:0]            alm_flag_o,
  output logic                       ts_flag_o,
  output logic                       tso_flag_o,
  output logic [CNT_W-1:0]           stamp_o,
  output logic                       irq_o
);
  logic [NALM-1:0] alm_evt_w;
  logic            reload_w;

  ssc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .reload_i(reload_w), .cnt_o(cnt_o)
  );

  for (genvar k = 0; k < NALM; k++) begin : g_alm
    ssc_alarm_unit #(.CNT_W(CNT_W), .MSK_W(MSK_W)) u_alm (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .cnt_i(cnt_o),
      .val_i(alm_val_i[k]), .msk_i(alm_msk_i[k]), .clr_i(alm_clr_i[k]),
      .evt_o(alm_evt_w[k]), .flag_o(alm_flag_o[k])
    );
  end

  assign reload_w = |(alm_evt_w & alm_reload_i);

  ssc_stamp_unit #(.CNT_W(CNT_W)) u_ts (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(cnt_o), .en_i(ts_en_i),
    .tamper_i(tamper_i), .ts_clr_i(ts_clr_i), .tso_clr_i(tso_clr_i),
    .ts_flag_o(ts_flag_o), .tso_flag_o(tso_flag_o), .stamp_o(stamp_o)
  );

  assign irq_o = (|(alm_flag_o & alm_ie_i)) || (ts_flag_o && ts_ie_i);

  // R1: cleared state one cycle after reset
  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |=> ((&cnt_o) && alm_flag_o == '0 && !ts_flag_o && !tso_flag_o));
endmodule

// File: tb/ssc_alarm_stamp_tb_top.sv
module ssc_alarm_stamp_tb_top;
  localparam int W = 32;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [1:0][W-1:0] aval = '0;
  logic [1:0][5:0] amsk = '0;
  logic [1:0] arel = '0, aclr = '0, aie = '0;
  logic ts_en = 1'b0, tamper = 1'b0, ts_clr = 1'b0, tso_clr = 1'b0, ts_ie = 1'b0;
  logic [W-1:0] cnt, stamp;
  logic [1:0] aflag;
  logic tsf, tsof, irq;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ssc_alarm_stamp dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .alm_val_i(aval), .alm_msk_i(amsk),
    .alm_reload_i(arel), .alm_clr_i(aclr), .alm_ie_i(aie), .ts_en_i(ts_en),
    .tamper_i(tamper), .ts_clr_i(ts_clr), .tso_clr_i(tso_clr), .ts_ie_i(ts_ie),
    .cnt_o(cnt), .alm_flag_o(aflag), .ts_flag_o(tsf), .tso_flag_o(tsof),
    .stamp_o(stamp), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask
  task automatic do_tick(); tick = 1'b1; step(); tick = 1'b0; endtask

  logic [W-1:0] model;

  task automatic t_reset();
    chk("R1 cnt", cnt, '1); chk("R1 alarm flags", W'(aflag), 0);
    chk("R1 ts flags", W'({tsf, tsof}), 0); chk("R1 irq", W'(irq), 0);
  endtask

  task automatic t_count();
    for (int i = 0; i < 3; i++) begin do_tick(); model--; end
    chk("R2 decrement", cnt, model);
    step(); step();
    chk("R2 hold without tick", cnt, model);
  endtask

  task automatic t_partial_mask();
    amsk[0] = 6'd4; aval[0] = 32'h0000_0009;
    for (int i = 0; i < 3; i++) begin do_tick(); model--; end
    chk("R4 no flag before match tick", W'(aflag[0]), 0);
    do_tick(); model--;
    chk("R4 flag after match tick (low 4 bits)", W'(aflag[0]), 1);
    chk("R5 decrement without auto-clear", cnt, model);
    aie = 2'b01; step();
    chk("R11 irq from alarm A", W'(irq), 1);
    aie = 2'b00; aclr[0] = 1'b1; step(); aclr[0] = 1'b0;
    chk("R7 clear alarm A", W'(aflag[0]), 0);
    do_tick(); model--;
    chk("R7 stays cleared without match", W'(aflag[0]), 0);
  endtask

  task automatic t_mask_zero();
    amsk[0] = 6'd0; amsk[1] = 6'd0; aval[1] = model; arel[1] = 1'b1;
    do_tick(); model--;
    chk("R3 zero mask no flag", W'(aflag[1]), 0);
    chk("R3 zero mask no reload", cnt, model);
    arel[1] = 1'b0;
  endtask

  task automatic t_reload();
    amsk[0] = 6'd32; aval[0] = model; arel[0] = 1'b1;
    do_tick(); model = '1;
    chk("R5 reload to all ones", cnt, model);
    chk("R5 flag on full compare", W'(aflag[0]), 1);
    aclr[0] = 1'b1; step(); aclr[0] = 1'b0;
  endtask

  task automatic t_rewrite();
    do_tick(); model--;
    aval[0] = model; step(); step();
    tick = 1'b1; aval[0] = '0; step(); tick = 1'b0; model = '1;
    chk("R6 reload despite rewrite", cnt, model);
    chk("R6 flag despite rewrite", W'(aflag[0]), 1);
    aclr[0] = 1'b1; step(); aclr[0] = 1'b0;
    chk("R7 clear after rewrite event", W'(aflag[0]), 0);
  endtask

  task automatic t_set_wins();
    arel[0] = 1'b0; amsk[1] = 6'd1; aval[1] = 32'h1;
    tick = 1'b1; aclr[1] = 1'b1; step(); tick = 1'b0; aclr[1] = 1'b0; model--;
    chk("R7 set wins over clear", W'(aflag[1]), 1);
    chk("R2 cnt after odd match", cnt, model);
    amsk[1] = 6'd0; aclr[1] = 1'b1; step(); aclr[1] = 1'b0;
    chk("R7 clear alarm B", W'(aflag[1]), 0);
  endtask

  task automatic t_stamp();
    tamper = 1'b1; step(); tamper = 1'b0;
    chk("R8 tamper ignored when disabled", W'({tsf, tsof}), 0);
    ts_en = 1'b1; tamper = 1'b1; step(); tamper = 1'b0;
    chk("R8 ts flag", W'(tsf), 1); chk("R8 stamp", stamp, model);
    chk("R11 irq masked", W'(irq), 0);
    ts_ie = 1'b1; step();
    chk("R11 irq from ts", W'(irq), 1);
    ts_ie = 1'b0;
    do_tick(); model--;
    tamper = 1'b1; step(); tamper = 1'b0;
    chk("R9 overflow flag", W'(tsof), 1); chk("R9 stamp kept", stamp, model + 1);
    do_tick(); model--;
    tamper = 1'b1; ts_clr = 1'b1; step(); tamper = 1'b0; ts_clr = 1'b0;
    chk("R10 tamper on clear cycle sets ts", W'(tsf), 1);
    chk("R10 tamper on clear cycle captures", stamp, model);
    tso_clr = 1'b1; step(); tso_clr = 1'b0;
    chk("R9 overflow cleared", W'(tsof), 0);
    ts_clr = 1'b1; step(); ts_clr = 1'b0;
    chk("R10 ts cleared", W'(tsf), 0);
    tamper = 1'b1; step(); tamper = 1'b0;
    chk("R10 tamper after clear sets ts", W'(tsf), 1);
    chk("R10 no overflow after clear", W'(tsof), 0);
  endtask

  initial begin
    model = '1;
    repeat (3) step();
    rst_n = 1'b1; step();
    t_reset();
    t_count();
    t_partial_mask();
    t_mask_zero();
    t_reload();
    t_rewrite();
    t_set_wins();
    t_stamp();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule